// File: doc/BRIEF.md
# Two-Wire Slave with Programmable Device Select

This block is a two-wire serial slave that runs entirely in the system clock domain. It oversamples the clock and data lines, finds START, repeated START and STOP, and decodes the first byte of each transfer as a control byte. That byte holds a fixed 4-bit device type code, a 3-bit device select field and a direction bit. When both the type code and the select field match, the slave acknowledges. It then either accepts bytes into a small register file or returns bytes from it.

In a write, the first data byte after the control byte sets a register pointer and each later byte is stored at the pointer, which then advances. In a read, bytes are returned from the pointer onward, most significant bit first, for as long as the master acknowledges. Register 0 holds the device select value. Writing it moves the slave to a new select value for every transfer addressed after the write. The data line is open drain: the output `sda_oe` pulls the line low when high and releases it when low.

Top module: `twi_slave`

## Requirements
- R1: After reset `sda_oe` and `busy` are low, the device select value is 000 and the pointer is 0; a read of register 0 then returns 0x00.
- R2: A control byte whose upper four bits are 1011 and whose bits 3..1 equal the select value is acknowledged by pulling SDA low during the ninth clock, and `busy` goes high at that point.
- R3: A control byte with a wrong type code or a wrong select field is not acknowledged, `busy` stays low, and no later byte is acknowledged until the next START.
- R4: In a write (bit 0 of the control byte = 0), the first data byte loads the pointer from its low three bits, every later byte is stored at the pointer, and the pointer then advances, wrapping from 7 to 0; every data byte is acknowledged.
- R5: In a read (bit 0 = 1), the slave sends the register at the pointer MSB first and advances the pointer after each byte, continuing while the master acknowledges.
- R6: After the master answers a byte with no acknowledge, the slave releases SDA, drops `busy`, and drives nothing more until the next START.
- R7: A write to register 0 replaces the select value with its low three bits; afterwards only the new value is acknowledged, and a read of register 0 returns the select value in bits 2..0 with the upper bits zero.
- R8: A STOP (SDA rising while SCL is high) at any point, including mid-byte, returns the slave to idle with SDA released and `busy` low.
- R9: A START (SDA falling while SCL is high) at any point, including a repeated START inside a transfer, restarts control-byte reception.
- R10: `sda_oe` changes only in the cycle after a detected SCL fall, except for its release after a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls the data line low; low releases it |
| busy | output | 1 | High while this slave is the addressed target of a transfer |

## Verification
The bench tries control bytes that differ from the matching one only in the type code, only in the select field, or not at all, so that a wrong decode of either field is visible. Write bursts that run past register 7 show whether the pointer wraps and whether the wrap lands on the address register, which in turn changes the address the slave answers to. Reads are tried with acknowledged multi-byte runs, with a no-acknowledge followed by extra clocks, and with a pointer at the last entry. A STOP in the middle of a byte and a repeated START after a rejected control byte show that the bus conditions override any state.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } twi_state_e;
endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // one stage past the synchroniser keeps the previous sample
  logic [SYNC_STAGES:0] scl_pipe;
  logic [SYNC_STAGES:0] sda_pipe;
  logic scl_now, scl_old, sda_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_now = scl_pipe[SYNC_STAGES-1];
  assign scl_old = scl_pipe[SYNC_STAGES];
  assign sda_s   = sda_pipe[SYNC_STAGES-1];
  assign sda_old = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twi_slave.sv
module twi_slave
  import twi_pkg::*;
#(
  parameter int               TYPE_W      = 4,
  parameter logic [TYPE_W-1:0] TYPE_CODE  = 4'b1011,
  parameter int               SEL_W       = 3,
  parameter int               NREGS       = 8,
  parameter int               SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic busy
);
  localparam int DATA_W = TYPE_W + SEL_W + 1;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int PTR_W  = $clog2(NREGS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  twi_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              full;
  logic              first_byte;
  logic              mack;
  logic              rw;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] tx;
  logic [PTR_W-1:0]  ptr;
  logic [SEL_W-1:0]  sel;
  logic              oe_q, busy_q;

  logic              we;
  logic [DATA_W-1:0] rd_mem, rd_byte;
  logic              type_ok, sel_ok;

  // a finished data byte in a write, past the pointer byte
  assign we = (state == ST_RX) && scl_fall && full && !first_byte;

  twi_regfile #(.DATA_W(DATA_W), .DEPTH(NREGS), .AW(PTR_W)) u_regs (
    .clk(clk), .we(we), .waddr(ptr), .wdata(sh), .raddr(ptr), .rdata(rd_mem)
  );

  // register 0 reads back the live select value
  assign rd_byte = (ptr == '0) ? DATA_W'(sel) : rd_mem;
  assign type_ok = (sh[DATA_W-1 -: TYPE_W] == TYPE_CODE);
  assign sel_ok  = (sh[SEL_W:1] == sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      full       <= 1'b0;
      first_byte <= 1'b0;
      mack       <= 1'b0;
      rw         <= 1'b0;
      sh         <= '0;
      tx         <= '0;
      ptr        <= '0;
      sel        <= '0;
      oe_q       <= 1'b0;
      busy_q     <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      full   <= 1'b0;
      oe_q   <= 1'b0;
      busy_q <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      oe_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            sh   <= {sh[DATA_W-2:0], sda_s};
            cnt  <= cnt + 1'b1;
            full <= (cnt == LAST_BIT);
          end else if (scl_fall && full) begin
            full <= 1'b0;
            if (state == ST_ADDR) begin
              if (type_ok && sel_ok) begin
                rw     <= sh[0];
                oe_q   <= 1'b1;
                busy_q <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              if (first_byte) begin
                ptr        <= sh[PTR_W-1:0];
                first_byte <= 1'b0;
              end else begin
                ptr <= ptr + 1'b1;
                if (ptr == '0) sel <= sh[SEL_W-1:0];
              end
              oe_q  <= 1'b1;
              state <= ST_RX_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx    <= rd_byte;
              oe_q  <= ~rd_byte[DATA_W-1];
              state <= ST_TX;
            end else begin
              oe_q       <= 1'b0;
              first_byte <= 1'b1;
              state      <= ST_RX;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            cnt   <= '0;
            state <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              oe_q  <= 1'b0;
              ptr   <= ptr + 1'b1;
              state <= ST_TX_ACK;
            end else begin
              tx   <= tx << 1;
              oe_q <= ~tx[DATA_W-2];
              cnt  <= cnt + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              tx    <= rd_byte;
              oe_q  <= ~rd_byte[DATA_W-1];
              state <= ST_TX;
            end else begin
              busy_q <= 1'b0;
              state  <= ST_IGNORE;
            end
          end
        end
        default: ;  // idle and ignore wait for a bus condition
      endcase
    end
  end

  assign sda_oe = oe_q;
  assign busy   = busy_q;
endmodule

// File: rtl/twi_slave_chk.sv
module twi_slave_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic busy,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det
);
  // the line is only pulled while this slave is addressed
  p_drive_only_addressed_r3: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> busy);

  // becoming addressed coincides with the address acknowledge
  p_addr_ack_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> sda_oe);

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && !busy));

  p_start_restart_r9: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!sda_oe && !busy));

  p_sda_on_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> $past(scl_fall));
endmodule

bind twi_slave twi_slave_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .busy(busy),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/twi_slave_bench.sv
module twi_slave_bench;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, busy;
  logic sda_line;
  logic cond = 1'b0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;
  int   nchk = 0;
  int   nfail = 0;
  int   viol = 0;

  logic [7:0] exp_val [$];
  string      exp_tag [$];
  logic [7:0] obs_q   [$];

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  twi_slave u_twi_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: compares every byte read back against the queue
  always @(negedge clk) begin
    while (obs_q.size() > 0) begin
      logic [7:0] got;
      got = obs_q.pop_front();
      if (exp_val.size() == 0) chk("R5 unexpected byte", {24'd0, got}, 32'hFFFF_FFFF);
      else chk(exp_tag.pop_front(), {24'd0, got}, {24'd0, exp_val.pop_front()});
    end
  end

  // R10: data output may only move while the bench holds SCL low
  always @(negedge clk) begin
    if (!rst && (sda_oe != prev_oe) && scl_m && !cond) viol++;
    prev_oe = sda_oe;
  end

  task automatic expect_byte(input string tag, input logic [7:0] v);
    exp_tag.push_back(tag);
    exp_val.push_back(v);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    cond = 1'b1; sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
    cond = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    cond = 1'b1; sda_m = 1'b1; wq(2*Q);
    cond = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = ~sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic give_ack);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_line; wq(Q);
      scl_m = 1'b0;
    end
    wq(Q);
    sda_m = ~give_ack; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
    obs_q.push_back(b);
  endtask

  initial begin
    logic a;
    wq(5);
    rst = 1'b0;
    wq(2);
    chk("R1 sda_oe after reset", {31'd0, sda_oe}, 32'd0);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);

    // read register 0 at the reset select value
    bus_start();
    send_byte(8'b1011_000_1, a);
    chk("R2 ack of matching read control", {31'd0, a}, 32'd1);
    chk("R2 busy when addressed", {31'd0, busy}, 32'd1);
    expect_byte("R1 reset select readback", 8'h00);
    recv_byte(1'b0);
    bus_stop();
    chk("R8 busy after stop", {31'd0, busy}, 32'd0);

    // wrong type code, then a data byte that must be ignored
    bus_start();
    send_byte(8'b1010_000_0, a);
    chk("R3 wrong type code not acked", {31'd0, a}, 32'd0);
    send_byte(8'h55, a);
    chk("R3 byte after mismatch not acked", {31'd0, a}, 32'd0);
    chk("R3 busy after mismatch", {31'd0, busy}, 32'd0);
    bus_stop();

    // wrong select field
    bus_start();
    send_byte(8'b1011_011_0, a);
    chk("R3 wrong select not acked", {31'd0, a}, 32'd0);
    bus_stop();

    // burst write from register 3, wrapping onto register 0
    bus_start();
    send_byte(8'b1011_000_0, a);
    chk("R2 ack of matching write control", {31'd0, a}, 32'd1);
    send_byte(8'h03, a);
    chk("R4 pointer byte acked", {31'd0, a}, 32'd1);
    foreach (exp_val[k]) ;
    send_byte(8'hA1, a); chk("R4 data ack 3", {31'd0, a}, 32'd1);
    send_byte(8'hB2, a); chk("R4 data ack 4", {31'd0, a}, 32'd1);
    send_byte(8'hC3, a); chk("R4 data ack 5", {31'd0, a}, 32'd1);
    send_byte(8'hD4, a); chk("R4 data ack 6", {31'd0, a}, 32'd1);
    send_byte(8'hE5, a); chk("R4 data ack 7", {31'd0, a}, 32'd1);
    send_byte(8'hF6, a); chk("R4 data ack wrap to 0", {31'd0, a}, 32'd1);
    bus_stop();

    // old select no longer answers
    bus_start();
    send_byte(8'b1011_000_0, a);
    chk("R7 old select rejected", {31'd0, a}, 32'd0);
    bus_stop();

    // new select, pointer 3, repeated start into a read
    bus_start();
    send_byte(8'b1011_110_0, a);
    chk("R7 new select acked", {31'd0, a}, 32'd1);
    send_byte(8'h03, a);
    chk("R4 pointer byte acked", {31'd0, a}, 32'd1);
    bus_start();
    send_byte(8'b1011_110_1, a);
    chk("R9 repeated start read acked", {31'd0, a}, 32'd1);
    expect_byte("R5 read reg3", 8'hA1);
    expect_byte("R5 read reg4", 8'hB2);
    expect_byte("R5 read reg5", 8'hC3);
    expect_byte("R5 read reg6", 8'hD4);
    recv_byte(1'b1);
    recv_byte(1'b1);
    recv_byte(1'b1);
    recv_byte(1'b0);
    expect_byte("R6 line released after nack", 8'hFF);
    recv_byte(1'b0);
    chk("R6 sda_oe after nack", {31'd0, sda_oe}, 32'd0);
    chk("R6 busy after nack", {31'd0, busy}, 32'd0);
    bus_stop();

    // read from the last entry, wrapping onto the select register
    bus_start();
    send_byte(8'b1011_110_0, a);
    send_byte(8'h07, a);
    chk("R4 pointer 7 acked", {31'd0, a}, 32'd1);
    bus_start();
    send_byte(8'b1011_110_1, a);
    chk("R9 second repeated start acked", {31'd0, a}, 32'd1);
    expect_byte("R5 read reg7", 8'hE5);
    expect_byte("R7 reg0 holds select only", 8'h06);
    recv_byte(1'b1);
    recv_byte(1'b0);
    bus_stop();

    // stop in the middle of a byte
    bus_start();
    send_byte(8'b1011_110_0, a);
    chk("R2 ack before mid-byte stop", {31'd0, a}, 32'd1);
    send_bits(8'h5A, 4);
    bus_stop();
    chk("R8 busy after mid-byte stop", {31'd0, busy}, 32'd0);
    chk("R8 sda_oe after mid-byte stop", {31'd0, sda_oe}, 32'd0);
    bus_start();
    send_byte(8'b1011_110_0, a);
    chk("R8 addressable after mid-byte stop", {31'd0, a}, 32'd1);
    bus_stop();

    // rejected control byte, then a repeated start with the right one
    bus_start();
    send_byte(8'b1011_001_0, a);
    chk("R3 select 001 rejected", {31'd0, a}, 32'd0);
    bus_start();
    send_byte(8'b1011_110_0, a);
    chk("R9 restart after rejection acked", {31'd0, a}, 32'd1);
    bus_stop();

    wq(4);
    chk("R10 sda_oe moved while SCL high", viol, 32'd0);
    chk("R5 scoreboard drained", exp_val.size(), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule